// File: doc/BRIEF.md
# Six-Instruction Multicycle Processor Core

A small 16-bit programmable core. It walks every instruction through a fetch cycle, a decode cycle and one execute cycle under a state-machine controller. Its datapath holds a register file of sixteen 16-bit registers with one write port and two read ports, an ALU that can pass, add or subtract, and a three-way multiplexer that chooses the value written back. Instruction memory and data memory sit outside the block. The core drives addresses and strobes to both and takes their read data back combinationally in the same cycle. Stores and register writes land on the clock edge that closes the execute cycle.

Each instruction is 16 bits. Bits [15:12] hold the opcode and bits [11:8] hold the destination or tested register `ra`. Depending on the opcode, bits [7:0] hold either an 8-bit address, constant or offset, or the two source registers `rb` [7:4] and `rc` [3:0]. A conditional jump adds a sign-extended offset to the address of the jump instruction itself. This gives forward and backward branches, so a program can loop and can park itself on a jump-to-self. The controller state appears on a port so that a bench can follow the sequence cycle by cycle.

Top module: `prog_cpu`

## Requirements
- R1: While `rst_ni` is low the state port reads 0 (init), the PC (`imem_addr_o`) reads 0 and no strobe is active. The first clock edge after release moves to fetch with PC 0.
- R2: In fetch (state 1) the core asserts `imem_rd_o`, presents PC on `imem_addr_o`, captures the returned word as the current instruction and advances PC by one. This is the only state that asserts `imem_rd_o`.
- R3: The state sequence is fetch (1), decode (2), then one execute state. The execute state codes are load 3, store 4, add 5, load-constant 6, subtract 7 and jump test 8; jump taken is 9. After execute the core returns to fetch. PC does not change in decode or in any execute state.
- R4: Opcode 0000 (load) asserts `dmem_rd_o` with address IR[7:0] and writes the returned word to `ra`.
- R5: Opcode 0001 (store) asserts `dmem_wr_o` for one cycle, with address IR[7:0] and write data equal to register `ra`. The two data strobes are never active together.
- R6: Opcode 0010 (add) writes `rb + rc` modulo 2^16 to `ra`. A source register that is also the destination supplies its old value.
- R7: Opcode 0100 (subtract) writes `rb - rc` modulo 2^16 to `ra`.
- R8: Opcode 0011 (load-constant) writes IR[7:0], zero-extended, to `ra`.
- R9: Opcode 0101 (jump-if-zero) with `ra` equal to zero adds a state 9 cycle. After that cycle PC equals the jump's own address plus the sign-extended offset IR[7:0].
- R10: Jump-if-zero with `ra` nonzero returns from state 8 to fetch with PC unchanged.
- R11: Opcodes 0110 to 1111 go from decode straight back to fetch. They raise no strobe and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 16 | Instruction address (the PC) |
| imem_rd_o | output | 1 | Instruction read strobe |
| imem_data_i | input | 16 | Instruction word, combinational from address |
| dmem_addr_o | output | 8 | Data memory address |
| dmem_rd_o | output | 1 | Data read strobe |
| dmem_wr_o | output | 1 | Data write strobe |
| dmem_wdata_o | output | 16 | Data memory write data |
| dmem_rdata_i | input | 16 | Data memory read data, combinational from address |
| state_o | output | 4 | Current controller state code |

## Verification
The add instruction reads its sources and writes its destination in the same execute cycle. The bench provokes this by doubling a register into itself with an operand of 0xFFFF. It then stores the result and expects 0xFFFE, which shows that the old value fed the ALU and that the sum wrapped. Fetch also writes the instruction register and advances the PC on one edge. Every cycle's state, PC and strobes are compared against a trace built from an instruction-level model, so a fetch that used the already-incremented PC would show up at once as a wrong opcode path.

// File: rtl/prog_cpu_pkg.sv
package prog_cpu_pkg;

  typedef enum logic [3:0] {
    ST_INIT   = 4'd0,
    ST_FETCH  = 4'd1,
    ST_DECODE = 4'd2,
    ST_LOAD   = 4'd3,
    ST_STORE  = 4'd4,
    ST_ADD    = 4'd5,
    ST_LDC    = 4'd6,
    ST_SUB    = 4'd7,
    ST_JZ     = 4'd8,
    ST_JZ_GO  = 4'd9
  } state_e;

  localparam logic [3:0] OP_LOAD  = 4'b0000;
  localparam logic [3:0] OP_STORE = 4'b0001;
  localparam logic [3:0] OP_ADD   = 4'b0010;
  localparam logic [3:0] OP_LDC   = 4'b0011;
  localparam logic [3:0] OP_SUB   = 4'b0100;
  localparam logic [3:0] OP_JZ    = 4'b0101;

  typedef enum logic [1:0] {
    WSEL_ALU = 2'b00,
    WSEL_MEM = 2'b01,
    WSEL_IMM = 2'b10
  } wsel_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'b00,
    ALU_ADD  = 2'b01,
    ALU_SUB  = 2'b10
  } alu_op_e;

endpackage

// File: rtl/prog_cpu_regfile.sv
module prog_cpu_regfile #(
  parameter int W    = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] p_addr_i,
  output logic [W-1:0]  p_data_o,
  input  logic [AW-1:0] q_addr_i,
  output logic [W-1:0]  q_data_o
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs[g] <= '0;
      else if (we_i && (waddr_i == AW'(unsigned'(g)))) regs[g] <= wdata_i;
    end
  end

  assign p_data_o = regs[p_addr_i];
  assign q_data_o = regs[q_addr_i];
endmodule

// File: rtl/prog_cpu_alu.sv
module prog_cpu_alu
  import prog_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/prog_cpu_ctrl.sv
module prog_cpu_ctrl
  import prog_cpu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] op_i,
  input  logic       rp_zero_i,
  output state_e     state_o,
  output logic       pc_clr_o,
  output logic       pc_inc_o,
  output logic       pc_ld_o,
  output logic       ir_ld_o,
  output logic       imem_rd_o,
  output logic       dmem_rd_o,
  output logic       dmem_wr_o,
  output logic       rf_we_o,
  output wsel_e      wsel_o,
  output alu_op_e    alu_op_o,
  output logic       rp_sel_rb_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_INIT;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    pc_clr_o    = 1'b0;
    pc_inc_o    = 1'b0;
    pc_ld_o     = 1'b0;
    ir_ld_o     = 1'b0;
    imem_rd_o   = 1'b0;
    dmem_rd_o   = 1'b0;
    dmem_wr_o   = 1'b0;
    rf_we_o     = 1'b0;
    wsel_o      = WSEL_ALU;
    alu_op_o    = ALU_PASS;
    rp_sel_rb_o = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        pc_clr_o = 1'b1;
        state_d  = ST_FETCH;
      end
      ST_FETCH: begin
        imem_rd_o = 1'b1;
        ir_ld_o   = 1'b1;
        pc_inc_o  = 1'b1;
        state_d   = ST_DECODE;
      end
      ST_DECODE: begin
        unique case (op_i)
          OP_LOAD:  state_d = ST_LOAD;
          OP_STORE: state_d = ST_STORE;
          OP_ADD:   state_d = ST_ADD;
          OP_LDC:   state_d = ST_LDC;
          OP_SUB:   state_d = ST_SUB;
          OP_JZ:    state_d = ST_JZ;
          default:  state_d = ST_FETCH;  // undefined opcode: no-op
        endcase
      end
      ST_LOAD: begin
        dmem_rd_o = 1'b1;
        rf_we_o   = 1'b1;
        wsel_o    = WSEL_MEM;
        state_d   = ST_FETCH;
      end
      ST_STORE: begin
        dmem_wr_o = 1'b1;
        state_d   = ST_FETCH;
      end
      ST_ADD: begin
        rp_sel_rb_o = 1'b1;
        alu_op_o    = ALU_ADD;
        rf_we_o     = 1'b1;
        state_d     = ST_FETCH;
      end
      ST_LDC: begin
        wsel_o  = WSEL_IMM;
        rf_we_o = 1'b1;
        state_d = ST_FETCH;
      end
      ST_SUB: begin
        rp_sel_rb_o = 1'b1;
        alu_op_o    = ALU_SUB;
        rf_we_o     = 1'b1;
        state_d     = ST_FETCH;
      end
      ST_JZ:    state_d = rp_zero_i ? ST_JZ_GO : ST_FETCH;
      ST_JZ_GO: begin
        pc_ld_o = 1'b1;
        state_d = ST_FETCH;
      end
      default:  state_d = ST_INIT;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/prog_cpu.sv
module prog_cpu
  import prog_cpu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DM_AW = 8,
  parameter int NREG  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [DW-1:0]    imem_addr_o,
  output logic             imem_rd_o,
  input  logic [DW-1:0]    imem_data_i,
  output logic [DM_AW-1:0] dmem_addr_o,
  output logic             dmem_rd_o,
  output logic             dmem_wr_o,
  output logic [DW-1:0]    dmem_wdata_o,
  input  logic [DW-1:0]    dmem_rdata_i,
  output logic [3:0]       state_o
);
  localparam int RAW = $clog2(NREG);
  localparam int IMW = 8;

  logic [DW-1:0] pc_q, ir_q;
  logic          pc_clr, pc_inc, pc_ld, ir_ld, rf_we, rp_sel_rb;
  wsel_e         wsel;
  alu_op_e       alu_op;
  state_e        state;

  logic [RAW-1:0] f_ra, f_rb, f_rc, rp_addr;
  logic [IMW-1:0] f_imm;
  logic [DW-1:0]  rp_data, rq_data, alu_y, wdata, jump_tgt;
  logic           rp_zero;

  assign f_ra  = ir_q[8 +: RAW];
  assign f_rb  = ir_q[4 +: RAW];
  assign f_rc  = ir_q[0 +: RAW];
  assign f_imm = ir_q[IMW-1:0];

  prog_cpu_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (ir_q[DW-1 -: 4]),
    .rp_zero_i  (rp_zero),
    .state_o    (state),
    .pc_clr_o   (pc_clr),
    .pc_inc_o   (pc_inc),
    .pc_ld_o    (pc_ld),
    .ir_ld_o    (ir_ld),
    .imem_rd_o  (imem_rd_o),
    .dmem_rd_o  (dmem_rd_o),
    .dmem_wr_o  (dmem_wr_o),
    .rf_we_o    (rf_we),
    .wsel_o     (wsel),
    .alu_op_o   (alu_op),
    .rp_sel_rb_o(rp_sel_rb)
  );

  assign rp_addr = rp_sel_rb ? f_rb : f_ra;

  prog_cpu_regfile #(.W(DW), .NREG(NREG)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (f_ra),
    .wdata_i (wdata),
    .p_addr_i(rp_addr),
    .p_data_o(rp_data),
    .q_addr_i(f_rc),
    .q_data_o(rq_data)
  );

  prog_cpu_alu #(.W(DW)) u_alu (
    .op_i(alu_op),
    .a_i (rp_data),
    .b_i (rq_data),
    .y_o (alu_y)
  );

  always_comb begin
    unique case (wsel)
      WSEL_MEM: wdata = dmem_rdata_i;
      WSEL_IMM: wdata = DW'(f_imm);
      default:  wdata = alu_y;
    endcase
  end

  assign rp_zero = ~|rp_data;
  // PC already points past the jump; the -1 lands the offset on the jump itself
  assign jump_tgt = pc_q + {{(DW-IMW){f_imm[IMW-1]}}, f_imm} - DW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_clr)      pc_q <= '0;
      else if (pc_ld)  pc_q <= jump_tgt;
      else if (pc_inc) pc_q <= pc_q + DW'(1);
      if (ir_ld)       ir_q <= imem_data_i;
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = ir_q[DM_AW-1:0];
  assign dmem_wdata_o = rp_data;
  assign state_o      = state;
endmodule

// File: rtl/prog_cpu_chk.sv
module prog_cpu_chk
  import prog_cpu_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] pc_i,
  input logic        imem_rd_i,
  input logic        dmem_rd_i,
  input logic        dmem_wr_i,
  input logic [3:0]  state_i
);
  // R1
  init_to_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_INIT |=> state_i == ST_FETCH && pc_i == 16'd0);
  // R2
  fetch_advances_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |=> pc_i == $past(pc_i) + 16'd1);
  // R2
  imem_rd_in_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_rd_i |-> state_i == ST_FETCH);
  // R3
  fetch_then_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |=> state_i == ST_DECODE);
  // R3
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i >= ST_DECODE && state_i <= ST_JZ) |=> $stable(pc_i));
  // R4
  load_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_rd_i |-> state_i == ST_LOAD);
  // R5
  strobes_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_rd_i && dmem_wr_i));
  // R5
  store_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_wr_i |=> !dmem_wr_i);
  // R9
  taken_to_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_JZ_GO |=> state_i == ST_FETCH);
  // R10
  jz_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_JZ |=> (state_i == ST_FETCH || state_i == ST_JZ_GO));
endmodule

bind prog_cpu prog_cpu_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_i     (imem_addr_o),
  .imem_rd_i(imem_rd_o),
  .dmem_rd_i(dmem_rd_o),
  .dmem_wr_i(dmem_wr_o),
  .state_i  (state_o)
);

// File: tb/prog_cpu_bench.sv
module prog_cpu_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_wdata, dmem_rdata;
  logic [7:0]  dmem_addr;
  logic        imem_rd, dmem_rd, dmem_wr;
  logic [3:0]  state;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];

  int n_chk = 0;
  int n_err = 0;
  bit mon_en = 1'b0;

  typedef struct packed {
    logic [3:0]  st;
    logic [15:0] pc;
    logic        ir;
    logic        dr;
    logic        dw;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  prog_cpu u_prog_cpu (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .imem_addr_o (imem_addr),
    .imem_rd_o   (imem_rd),
    .imem_data_i (imem_data),
    .dmem_addr_o (dmem_addr),
    .dmem_rd_o   (dmem_rd),
    .dmem_wr_o   (dmem_wr),
    .dmem_wdata_o(dmem_wdata),
    .dmem_rdata_i(dmem_rdata),
    .state_o     (state)
  );

  assign imem_data  = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_wr) dmem[dmem_addr] <= dmem_wdata;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] s);
    case (s)
      4'd1:    return "R2";
      4'd3:    return "R4";
      4'd4:    return "R5";
      4'd8:    return "R10";
      4'd9:    return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic push(int st, logic [15:0] pc, bit ir, bit dr, bit dw);
    item_t e;
    e.st = st[3:0]; e.pc = pc; e.ir = ir; e.dr = dr; e.dw = dw;
    exp_q.push_back(e);
  endtask

  // instruction-level model: pushes the expected per-cycle trace
  task automatic predict();
    logic [15:0] mpc = '0;
    logic [15:0] mrf [16];
    logic [15:0] mdm [256];
    for (int i = 0; i < 16; i++) mrf[i] = '0;
    for (int i = 0; i < 256; i++) mdm[i] = dmem[i];
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ir;
      ir = imem[mpc[7:0]];
      push(1, mpc, 1, 0, 0);
      mpc = mpc + 16'd1;
      push(2, mpc, 0, 0, 0);
      case (ir[15:12])
        4'h0: begin push(3, mpc, 0, 1, 0); mrf[ir[11:8]] = mdm[ir[7:0]]; end
        4'h1: begin push(4, mpc, 0, 0, 1); mdm[ir[7:0]] = mrf[ir[11:8]]; end
        4'h2: begin push(5, mpc, 0, 0, 0); mrf[ir[11:8]] = mrf[ir[7:4]] + mrf[ir[3:0]]; end
        4'h3: begin push(6, mpc, 0, 0, 0); mrf[ir[11:8]] = {8'h00, ir[7:0]}; end
        4'h4: begin push(7, mpc, 0, 0, 0); mrf[ir[11:8]] = mrf[ir[7:4]] - mrf[ir[3:0]]; end
        4'h5: begin
          push(8, mpc, 0, 0, 0);
          if (mrf[ir[11:8]] == 16'd0) begin
            push(9, mpc, 0, 0, 0);
            if (ir[7:0] == 8'd0) return;
            mpc = mpc + {{8{ir[7]}}, ir[7:0]} - 16'd1;
          end
        end
        default: ;
      endcase
    end
  endtask

  // monitor: compares each cycle against the scoreboard queue
  always @(negedge clk) begin
    item_t e, a;
    if (mon_en && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      a = {state, imem_addr, imem_rd, dmem_rd, dmem_wr};
      chk(a == e, tag_of(e.st), 32'(a), 32'(e));
    end
  end

  task automatic load_prog(int sel, logic [15:0] d5);
    for (int i = 0; i < 256; i++) begin imem[i] = 16'h0; dmem[i] = 16'h0; end
    if (sel == 0) begin
      dmem[0] = 16'd99; dmem[1] = 16'd102; dmem[2] = 16'hFFFF;
      imem[0]  = 16'h3F00; // ldc r15,#0
      imem[1]  = 16'h0000; // ld r0,[0]
      imem[2]  = 16'h0101; // ld r1,[1]
      imem[3]  = 16'h2201; // add r2,r0,r1
      imem[4]  = 16'h1209; // st [9],r2
      imem[5]  = 16'h0302; // ld r3,[2]
      imem[6]  = 16'h2333; // add r3,r3,r3
      imem[7]  = 16'h130A; // st [10],r3
      imem[8]  = 16'h34FF; // ldc r4,#ff
      imem[9]  = 16'h4540; // sub r5,r4,r0
      imem[10] = 16'h4601; // sub r6,r0,r1
      imem[11] = 16'h150B;
      imem[12] = 16'h160C;
      imem[13] = 16'h140D;
      imem[14] = 16'h7123; // undefined
      imem[15] = 16'hF1FF; // undefined
      imem[16] = 16'h110E; // st [14],r1
      imem[17] = 16'h5F00; // park
    end else begin
      dmem[4] = 16'd7; dmem[5] = d5;
      imem[0]  = 16'h3001; // ldc r0,#1
      imem[1]  = 16'h3F00;
      imem[2]  = 16'h0104; // ld r1,[4]
      imem[3]  = 16'h0205; // ld r2,[5]
      imem[4]  = 16'h4312; // sub r3,r1,r2
      imem[5]  = 16'h5302; // jz r3,+2
      imem[6]  = 16'h3000; // ldc r0,#0
      imem[7]  = 16'h1003; // st [3],r0
      imem[8]  = 16'h3503; // r5 = 3
      imem[9]  = 16'h3601; // r6 = 1
      imem[10] = 16'h3700; // r7 = 0
      imem[11] = 16'h2775; // r7 += r5
      imem[12] = 16'h4556; // r5 -= r6
      imem[13] = 16'h5502; // jz r5,+2
      imem[14] = 16'h5FFD; // jz r15,-3 (back to 11)
      imem[15] = 16'h1706; // st [6],r7
      imem[16] = 16'h5F00; // park
    end
  endtask

  task automatic run(int sel, logic [15:0] d5);
    int n = 0;
    @(negedge clk);
    rst_ni = 1'b0;
    mon_en = 1'b0;
    exp_q.delete();
    load_prog(sel, d5);
    predict();
    @(negedge clk);
    // R1
    chk(state == 4'd0 && imem_addr == 16'd0 && !imem_rd && !dmem_rd && !dmem_wr,
        "R1", {state, imem_addr, imem_rd, dmem_rd, dmem_wr}, 32'h0);
    rst_ni = 1'b1;
    #1 mon_en = 1'b1;
    while (exp_q.size() > 0 && n < 3000) begin @(posedge clk); n++; end
    if (exp_q.size() > 0) begin
      chk(1'b0, "watchdog", 32'(exp_q.size()), 32'h0);
      exp_q.delete();
    end
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin
    run(0, 16'd0);
    chk(dmem[9]  == 16'd201,   "R6",  dmem[9],  16'd201);
    chk(dmem[10] == 16'hFFFE,  "R6",  dmem[10], 16'hFFFE);
    chk(dmem[11] == 16'd156,   "R7",  dmem[11], 16'd156);
    chk(dmem[12] == 16'hFFFD,  "R7",  dmem[12], 16'hFFFD);
    chk(dmem[13] == 16'h00FF,  "R8",  dmem[13], 16'h00FF);
    chk(dmem[14] == 16'd102,   "R11", dmem[14], 16'd102);
    chk(dmem[8]  == 16'd0,     "R11", dmem[8],  16'd0);
    run(1, 16'd7);
    chk(dmem[3] == 16'd1, "R9",  dmem[3], 16'd1);
    chk(dmem[6] == 16'd6, "R9",  dmem[6], 16'd6);
    run(1, 16'd8);
    chk(dmem[3] == 16'd0, "R10", dmem[3], 16'd0);
    chk(dmem[6] == 16'd6, "R10", dmem[6], 16'd6);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule